// File: doc/BRIEF.md
# Programmable Tap Delay Controller

This block models one pin's delay element in digital form. A fast tap clock drives a shift chain with one stage per tap. The output is read from the stage that the selected tap value picks. A signal that leaves the block has therefore waited one tap clock per stage it passed, and the selected tap sets that number.

The element holds two tap values, one for each direction of traffic.

- **Input tap:** its behaviour is set by a mode parameter.
  - In the zero-latency default mode the input tap is held at zero.
  - In the fixed mode it is locked to a preset.
  - In the variable mode it starts at a preset and is then stepped up or down at run time, one tap per enabled clock, wrapping at both ends.
- **Output tap:** it is always locked to its own preset.
- **Direction input:** chooses which tap value is used, so input and output traffic can share the element in turn. A readback port shows the tap in use.

The preset-based modes rely on an external calibration reference. A small state machine has two states:

- **ST_WAIT_CAL:** the data output is forced low and tap stepping is refused.
- **ST_LIVE:** normal operation.

It has two transitions:

- **CAL_SEEN** (ST_WAIT_CAL to ST_LIVE) is taken on a clock edge where the calibration-ready input is high.
- **CAL_LOST** (ST_LIVE to ST_WAIT_CAL) is taken on a clock edge where that input is low.

Reset enters ST_WAIT_CAL in the fixed and variable modes. In the default mode reset enters ST_LIVE, and the machine never leaves it.

Top module: `tap_delay_ctrl`

## Requirements
- R1: In variable mode, while calibrated, each rising clock edge with `adj_en` high moves the input tap by exactly one step: up when `adj_up` is 1, down when it is 0. The new value shows on `tap_now` after that edge, and an edge with `adj_en` low leaves the tap unchanged.
- R2: Tap stepping wraps: up from 63 gives 0, and down from 0 gives 63. There are 64 taps, numbered 0 to 63, on a 6-bit readback.
- R3: In fixed mode the input tap equals `IN_PRESET` from reset onward, and `adj_en`/`adj_up` have no effect on it.
- R4: In default mode the input tap is 0 and `adj_en`/`adj_up` have no effect on it. The data output runs without `cal_ok`, including while `cal_ok` is low.
- R5: The output tap equals `OUT_PRESET` in every mode and never changes.
- R6: `dir_tx` = 0 selects the input tap and `dir_tx` = 1 selects the output tap. The selection applies both to `tap_now` and to the data path.
- R7: `sig_out` equals `sig_in` delayed by (selected tap + 1) tap-clock cycles.
- R8: In fixed and variable modes `sig_out` is 0 while the block is in ST_WAIT_CAL. The block enters ST_LIVE one edge after `cal_ok` is seen high and returns to ST_WAIT_CAL one edge after `cal_ok` is seen low.
- R9: In variable mode the input tap resets to `IN_PRESET`. `adj_en` is ignored while the block is in ST_WAIT_CAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tap clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Data entering the chain |
| dir_tx | input | 1 | 0 selects the input tap, 1 selects the output tap |
| adj_en | input | 1 | Enables one tap step on this edge (variable mode) |
| adj_up | input | 1 | Step direction: 1 up, 0 down |
| cal_ok | input | 1 | Calibration reference is ready |
| sig_out | output | 1 | Delayed data |
| tap_now | output | 6 | Tap value currently applied |

## Verification
The bench builds three copies side by side, all with the full 64 taps and an output preset of 40:
- a variable-mode copy with an input preset of 5;
- a fixed-mode copy with an input preset of 9;
- a default-mode copy.

Because the variable copy is driven up and then down for more than a full turn, every tap value from 0 to 63 is exercised, including both wrap points. At each of those values the bench compares the delayed output against an arithmetic history of the pseudo-random input. Sharing inputs across the three copies shows that stepping commands reach only the variable copy. The direction switch and the calibration gating are exercised on all three copies.

// File: rtl/tap_delay_pkg.sv
package tap_delay_pkg;
    typedef enum logic [1:0] {
        MODE_DEFAULT  = 2'd0,
        MODE_FIXED    = 2'd1,
        MODE_VARIABLE = 2'd2
    } in_mode_e;

    typedef enum logic {
        ST_WAIT_CAL = 1'b0,
        ST_LIVE     = 1'b1
    } cal_state_e;
endpackage

// File: rtl/tap_cal_fsm.sv
module tap_cal_fsm #(
    parameter bit NEED_CAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_ok,
    output logic live
);
    import tap_delay_pkg::*;

    localparam cal_state_e RESET_ST = NEED_CAL ? ST_WAIT_CAL : ST_LIVE;

    cal_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_ST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_CAL: if (cal_ok || !NEED_CAL) state_d = ST_LIVE;      // CAL_SEEN
            ST_LIVE:     if (!cal_ok && NEED_CAL) state_d = ST_WAIT_CAL;  // CAL_LOST
            default:     state_d = RESET_ST;
        endcase
    end

    always_comb begin
        live = (state_q == ST_LIVE);
    end

    AST_CAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cal_ok |=> live);                                          // R8
    AST_CAL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (NEED_CAL && !cal_ok) |=> !live);                          // R8
    AST_NO_CAL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !NEED_CAL |=> live);                                       // R4
endmodule

// File: rtl/tap_step_counter.sv
module tap_step_counter #(
    parameter int NUM_TAPS = 64,
    parameter tap_delay_pkg::in_mode_e IN_MODE = tap_delay_pkg::MODE_VARIABLE,
    parameter int IN_PRESET = 0,
    localparam int TAP_W = $clog2(NUM_TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live,
    input  logic             adj_en,
    input  logic             adj_up,
    output logic [TAP_W-1:0] in_tap
);
    import tap_delay_pkg::*;

    localparam logic [TAP_W-1:0] LAST_TAP  = TAP_W'(NUM_TAPS - 1);
    localparam logic [TAP_W-1:0] PRESET_T  = TAP_W'(IN_PRESET);
    localparam logic [TAP_W-1:0] RESET_TAP = (IN_MODE == MODE_DEFAULT) ? '0 : PRESET_T;
    localparam bit               CAN_STEP  = (IN_MODE == MODE_VARIABLE);

    logic [TAP_W-1:0] tap_up, tap_dn;

    always_comb begin
        tap_up = (in_tap == LAST_TAP) ? '0 : in_tap + 1'b1;
        tap_dn = (in_tap == '0) ? LAST_TAP : in_tap - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       in_tap <= RESET_TAP;
        else if (CAN_STEP && live && adj_en) in_tap <= adj_up ? tap_up : tap_dn;
    end

    generate
        if (CAN_STEP) begin : g_var_chk
            AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
                (live && adj_en && adj_up) |=>
                    (in_tap == (($past(in_tap) == LAST_TAP) ? '0 : $past(in_tap) + 1'b1))); // R1
            AST_STEP_DN: assert property (@(posedge clk) disable iff (!rst_n)
                (live && adj_en && !adj_up) |=>
                    (in_tap == (($past(in_tap) == '0) ? LAST_TAP : $past(in_tap) - 1'b1))); // R2
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                (!adj_en || !live) |=> $stable(in_tap));                 // R9
        end else begin : g_lock_chk
            AST_LOCKED_TAP: assert property (@(posedge clk) disable iff (!rst_n)
                adj_en |=> $stable(in_tap));                             // R3
        end
    endgenerate
endmodule

// File: rtl/tap_shift_chain.sv
module tap_shift_chain #(
    parameter int NUM_TAPS = 64,
    localparam int TAP_W = $clog2(NUM_TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [TAP_W-1:0] sel,
    output logic             tapped
);
    logic [NUM_TAPS-1:0] stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[NUM_TAPS-2:0], sig_in};
    end

    always_comb begin
        tapped = stage[sel];
    end

    AST_FIRST_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage[0] == $past(sig_in)));                           // R7
endmodule

// File: rtl/tap_delay_ctrl.sv
module tap_delay_ctrl #(
    parameter int NUM_TAPS = 64,
    parameter tap_delay_pkg::in_mode_e IN_MODE = tap_delay_pkg::MODE_VARIABLE,
    parameter int IN_PRESET = 0,
    parameter int OUT_PRESET = 0,
    localparam int TAP_W = $clog2(NUM_TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             dir_tx,
    input  logic             adj_en,
    input  logic             adj_up,
    input  logic             cal_ok,
    output logic             sig_out,
    output logic [TAP_W-1:0] tap_now
);
    import tap_delay_pkg::*;

    localparam bit               NEED_CAL = (IN_MODE != MODE_DEFAULT);
    localparam logic [TAP_W-1:0] OUT_TAP  = TAP_W'(OUT_PRESET);

    logic             live;
    logic [TAP_W-1:0] in_tap;
    logic             tapped;

    tap_cal_fsm #(.NEED_CAL(NEED_CAL)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cal_ok (cal_ok),
        .live   (live)
    );

    tap_step_counter #(
        .NUM_TAPS  (NUM_TAPS),
        .IN_MODE   (IN_MODE),
        .IN_PRESET (IN_PRESET)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .live   (live),
        .adj_en (adj_en),
        .adj_up (adj_up),
        .in_tap (in_tap)
    );

    always_comb begin
        tap_now = dir_tx ? OUT_TAP : in_tap;
    end

    tap_shift_chain #(.NUM_TAPS(NUM_TAPS)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_in),
        .sel    (tap_now),
        .tapped (tapped)
    );

    always_comb begin
        sig_out = live & tapped;
    end

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (NEED_CAL && !cal_ok) |=> !sig_out);                             // R8
    AST_OUT_TAP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_tx && $past(dir_tx)) |-> $stable(tap_now));                 // R5
endmodule

// File: tb/tap_delay_ctrl_tb.sv
module tap_delay_ctrl_tb;
    import tap_delay_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_in = 1'b0, dir_tx = 1'b0, adj_en = 1'b0, adj_up = 1'b0, cal_ok = 1'b0;
    logic o_var, o_fix, o_def;
    logic [5:0] t_var, t_fix, t_def;

    int checks = 0;
    int errors = 0;
    logic [63:0] hist = '0;
    logic [5:0] exp_var = 6'd5;
    logic rdy_m = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    tap_delay_ctrl #(.NUM_TAPS(64), .IN_MODE(MODE_VARIABLE), .IN_PRESET(5), .OUT_PRESET(40)) u_dut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .dir_tx(dir_tx), .adj_en(adj_en),
        .adj_up(adj_up), .cal_ok(cal_ok), .sig_out(o_var), .tap_now(t_var));
    tap_delay_ctrl #(.NUM_TAPS(64), .IN_MODE(MODE_FIXED), .IN_PRESET(9), .OUT_PRESET(40)) u_dut_fix (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .dir_tx(dir_tx), .adj_en(adj_en),
        .adj_up(adj_up), .cal_ok(cal_ok), .sig_out(o_fix), .tap_now(t_fix));
    tap_delay_ctrl #(.NUM_TAPS(64), .IN_MODE(MODE_DEFAULT), .IN_PRESET(9), .OUT_PRESET(40)) u_dut_def (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .dir_tx(dir_tx), .adj_en(adj_en),
        .adj_up(adj_up), .cal_ok(cal_ok), .sig_out(o_def), .tap_now(t_def));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock edge; bench models chain history and the variable tap
    task automatic tick();
        @(posedge clk);
        #1;
        hist = {hist[62:0], sig_in};
        if (rst_n && adj_en && rdy_m) exp_var = adj_up ? exp_var + 6'd1 : exp_var - 6'd1;
        rdy_m = rst_n & cal_ok;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sig_in = rst_n ? lfsr[0] : 1'b0;
    endtask

    task automatic check_all(input string tag);
        logic [5:0] in_v, sel_v, sel_f, sel_d;
        in_v  = exp_var;
        sel_v = dir_tx ? 6'd40 : in_v;
        sel_f = dir_tx ? 6'd40 : 6'd9;
        sel_d = dir_tx ? 6'd40 : 6'd0;
        chk({tag, " R1 R6 var tap"}, t_var, sel_v);
        chk({tag, " R3 R6 fixed tap"}, t_fix, sel_f);
        chk({tag, " R4 R6 default tap"}, t_def, sel_d);
        chk({tag, " R7 var data"}, o_var, rdy_m ? hist[sel_v] : 1'b0);
        chk({tag, " R7 fixed data"}, o_fix, rdy_m ? hist[sel_f] : 1'b0);
        chk({tag, " R7 default data"}, o_def, hist[sel_d]);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // reset state
        chk("R9 var reset tap", t_var, 5);
        chk("R3 fixed reset tap", t_fix, 9);
        chk("R4 default reset tap", t_def, 0);
        chk("R8 var out low at reset", o_var, 0);
        chk("R8 fixed out low at reset", o_fix, 0);

        // uncalibrated: stepping refused, gated output, default live
        adj_en = 1'b1; adj_up = 1'b1;
        for (int i = 0; i < 70; i++) begin
            tick();
            chk("R8 var gated", o_var, 0);
            chk("R8 fixed gated", o_fix, 0);
            chk("R9 var tap held uncalibrated", t_var, 5);
            chk("R4 default live without cal", o_def, hist[0]);
        end

        // calibrate; state goes live one edge later
        adj_en = 1'b0; cal_ok = 1'b1;
        tick();
        chk("R8 var live after cal", o_var, hist[5]);
        check_all("cal");

        // sweep up past the 63->0 wrap
        adj_en = 1'b1; adj_up = 1'b1;
        for (int i = 0; i < 66; i++) begin
            tick();
            check_all("up");
        end
        chk("R2 wrapped up", t_var, 7);
        // sweep down past the 0->63 wrap
        adj_up = 1'b0;
        for (int i = 0; i < 70; i++) begin
            tick();
            check_all("down");
        end
        chk("R2 wrapped down", t_var, 1);

        // sparse stepping with random direction
        for (int i = 0; i < 200; i++) begin
            adj_en = lfsr[3]; adj_up = lfsr[7];
            tick();
            check_all("rand");
        end

        // output direction
        dir_tx = 1'b1;
        for (int i = 0; i < 20; i++) begin
            adj_en = lfsr[2]; adj_up = lfsr[5];
            tick();
            check_all("tx");
            chk("R5 output tap", t_var, 40);
        end
        dir_tx = 1'b0; adj_en = 1'b0;
        tick();
        check_all("R6 back to rx");

        // calibration lost
        cal_ok = 1'b0;
        tick();
        chk("R8 var gated after loss", o_var, 0);
        chk("R8 fixed gated after loss", o_fix, 0);
        check_all("loss");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule